// File: doc/BRIEF.md
# GPIO Line Interrupt Unit

This block turns up to 32 general-purpose input lines into interrupt requests. Each line is brought into the bus clock domain through a two-flop synchronizer. A line can optionally pass through a sampling filter that rejects short glitches. It is then judged against its own trigger settings. A line can be level sensitive, where its status tracks the pin as long as the pin sits at the chosen level. It can instead be edge sensitive, where a transition in the chosen direction sets a sticky status bit that software clears by writing a one to it.

Software configures the unit over a simple APB-style register bus. It reads the synchronized pin levels, the unmasked (raw) status and the masked status. A single registered, active-high interrupt output is the OR of every masked status bit. When enabled by a parameter, one registered output per line copies that line's masked status. Software that wants both edges of a line flips that line's polarity bit after each event.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every configuration register, both status views, `irq_o` and `irq_line_o` read as zero.
- R2: The configuration registers read back what was written: line enable at byte offset 0x30, line mask at 0x34, debounce enable at 0x48, polarity at 0x3C and trigger select at 0x38. The clear register at 0x4C always reads zero. Reads are combinational while `psel` is high and `pwrite` is low. A write takes effect on the clock edge where `psel`, `penable` and `pwrite` are all high.
- R3: Offset 0x50 returns the pin levels after a two-stage synchronizer. A pin change becomes visible after two rising clock edges and not after one.
- R4: A line whose enable bit is 0 never shows raw status, whatever its pin does.
- R5: Trigger bit 0 selects level sensing. Polarity 1 means active-high and polarity 0 means active-low. Raw status (offset 0x44) follows the live level and drops when the pin returns to its inactive level, with no clear needed.
- R6: Trigger bit 1 selects edge sensing. Polarity 1 means a rising edge and polarity 0 means a falling edge. The event is latched and stays set after the pin returns.
- R7: Writing a 1 to a bit of offset 0x4C clears only that line's latched edge, and bits written 0 are untouched. If a new edge arrives in the same cycle as the clear, the edge wins.
- R8: A mask bit of 1 removes the line from masked status (offset 0x40), from `irq_o` and from `irq_line_o`. Raw status at 0x44 is not affected by the mask.
- R9: `irq_o` equals the OR of the masked status of the previous cycle. `irq_line_o` carries each line's masked status of the previous cycle.
- R10: From a pin change, a non-debounced level line raises `irq_o` on the third rising edge and an edge line raises it on the fourth. It is still low one edge earlier in both cases.
- R11: With its debounce bit set, a line is accepted only after the synchronized input has held a new value for DB_LEN consecutive cycles (default 4). A level line then raises `irq_o` on edge 3+DB_LEN, and a pulse shorter than DB_LEN cycles is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register bus select |
| penable | input | 1 | Register bus access phase |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational |
| pins_i | input | NLINES | Asynchronous input lines |
| irq_o | output | 1 | Combined interrupt, active high |
| irq_line_o | output | NLINES | Per-line masked interrupts |

## Verification
Each result has a fixed latency, counted in rising edges from the negative edge on which the bench changes a pin:
- the external-pin view: two edges;
- a level status: two edges, with `irq_o` following on the third;
- a latched edge: three edges, with `irq_o` on the fourth;
- a debounced level line: DB_LEN edges more than a level status.

The latency checks sample one edge before each due point and expect the old value, then sample at the due point and expect the new one, always on a falling edge. The sweep over every combination of enable, mask, trigger and polarity waits well past these latencies before it reads status, so its expected values depend only on the settled behaviour. The same-cycle clear test places the access phase of the clear write on the exact edge where the new edge is latched.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
    localparam int unsigned OFS_ENABLE   = 32'h30;
    localparam int unsigned OFS_MASK     = 32'h34;
    localparam int unsigned OFS_TRIGGER  = 32'h38;
    localparam int unsigned OFS_POLARITY = 32'h3C;
    localparam int unsigned OFS_STATUS   = 32'h40;
    localparam int unsigned OFS_RAW      = 32'h44;
    localparam int unsigned OFS_DEBOUNCE = 32'h48;
    localparam int unsigned OFS_CLEAR    = 32'h4C;
    localparam int unsigned OFS_PINS     = 32'h50;
    localparam int unsigned BUS_W        = 32;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_debounce.sv
module gpio_irq_debounce #(
    parameter int unsigned W      = 32,
    parameter int unsigned DB_LEN = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] filt
);
    localparam int unsigned CW  = $clog2(DB_LEN + 1);
    localparam int unsigned LIM = DB_LEN - 1;

    logic [W-1:0]         filt_d, filt_q;
    logic [W-1:0][CW-1:0] cnt_d, cnt_q;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            filt_d[i] = filt_q[i];
            cnt_d[i]  = cnt_q[i];
            if (raw[i] == filt_q[i]) begin
                cnt_d[i] = '0;
            end else if (cnt_q[i] == CW'(LIM)) begin
                filt_d[i] = raw[i];
                cnt_d[i]  = '0;
            end else begin
                cnt_d[i] = cnt_q[i] + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= '0;
            cnt_q  <= '0;
        end else begin
            filt_q <= filt_d;
            cnt_q  <= cnt_d;
        end
    end

    assign filt = filt_q;

    for (genvar g = 0; g < W; g++) begin : g_line_chk
        // R11
        db_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (filt_q[g] != $past(filt_q[g])) |-> ($past(cnt_q[g]) == CW'(LIM)));
    end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_in,
    input  logic [W-1:0] en,
    input  logic [W-1:0] trig,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] clr,
    output logic [W-1:0] raw_stat
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] latch;
    } det_t;

    det_t         st_d, st_q;
    logic [W-1:0] edge_set;
    logic [W-1:0] lvl_hit;

    always_comb begin
        edge_set = en & trig & ((pol & level_in & ~st_q.prev) |
                                (~pol & ~level_in & st_q.prev));
        lvl_hit  = en & ~trig & ~(level_in ^ pol);
        st_d.prev  = level_in;
        st_d.latch = (st_q.latch & ~clr) | edge_set;
        raw_stat   = lvl_hit | (st_q.latch & en & trig);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_set != '0) |=> ((st_q.latch & $past(edge_set)) == $past(edge_set)));

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~st_q.latch & $past(st_q.latch) & ~$past(clr)) == '0));

    // R4
    no_disabled_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.latch & ~$past(st_q.latch) & ~$past(en)) == '0));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NLINES       = 32,
    parameter int unsigned DB_LEN       = 4,
    parameter int unsigned ADDR_W       = 8,
    parameter bit          PER_LINE_IRQ = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    input  logic [NLINES-1:0] pins_i,
    output logic              irq_o,
    output logic [NLINES-1:0] irq_line_o
);
    typedef struct packed {
        logic [NLINES-1:0] en;
        logic [NLINES-1:0] mask;
        logic [NLINES-1:0] trig;
        logic [NLINES-1:0] pol;
        logic [NLINES-1:0] deb;
    } cfg_t;

    typedef struct packed {
        logic              irq;
        logic [NLINES-1:0] line;
    } out_t;

    cfg_t              cfg_d, cfg_q;
    out_t              out_d, out_q;
    logic              wr_en;
    logic [NLINES-1:0] wdata;
    logic [NLINES-1:0] clr_vec;
    logic [NLINES-1:0] pin_sync, pin_filt, qual;
    logic [NLINES-1:0] raw_stat, masked;

    gpio_irq_sync #(.W(NLINES), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pins_i), .dout(pin_sync)
    );

    gpio_irq_debounce #(.W(NLINES), .DB_LEN(DB_LEN)) u_deb (
        .clk(clk), .rst_n(rst_n), .raw(pin_sync), .filt(pin_filt)
    );

    assign qual = (cfg_q.deb & pin_filt) | (~cfg_q.deb & pin_sync);

    gpio_irq_detect #(.W(NLINES)) u_det (
        .clk(clk), .rst_n(rst_n), .level_in(qual),
        .en(cfg_q.en), .trig(cfg_q.trig), .pol(cfg_q.pol),
        .clr(clr_vec), .raw_stat(raw_stat)
    );

    always_comb begin
        wr_en   = psel & penable & pwrite;
        wdata   = pwdata[NLINES-1:0];
        cfg_d   = cfg_q;
        clr_vec = '0;
        if (wr_en) begin
            case (paddr)
                ADDR_W'(OFS_ENABLE):   cfg_d.en   = wdata;
                ADDR_W'(OFS_MASK):     cfg_d.mask = wdata;
                ADDR_W'(OFS_TRIGGER):  cfg_d.trig = wdata;
                ADDR_W'(OFS_POLARITY): cfg_d.pol  = wdata;
                ADDR_W'(OFS_DEBOUNCE): cfg_d.deb  = wdata;
                ADDR_W'(OFS_CLEAR):    clr_vec    = wdata;
                default: ;
            endcase
        end
        masked    = raw_stat & ~cfg_q.mask;
        out_d.irq  = |masked;
        out_d.line = masked;
    end

    always_comb begin
        prdata = '0;
        if (psel && !pwrite) begin
            case (paddr)
                ADDR_W'(OFS_ENABLE):   prdata = BUS_W'(cfg_q.en);
                ADDR_W'(OFS_MASK):     prdata = BUS_W'(cfg_q.mask);
                ADDR_W'(OFS_TRIGGER):  prdata = BUS_W'(cfg_q.trig);
                ADDR_W'(OFS_POLARITY): prdata = BUS_W'(cfg_q.pol);
                ADDR_W'(OFS_STATUS):   prdata = BUS_W'(masked);
                ADDR_W'(OFS_RAW):      prdata = BUS_W'(raw_stat);
                ADDR_W'(OFS_DEBOUNCE): prdata = BUS_W'(cfg_q.deb);
                ADDR_W'(OFS_PINS):     prdata = BUS_W'(pin_sync);
                default:               prdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            out_q <= '0;
        end else begin
            cfg_q <= cfg_d;
            out_q <= out_d;
        end
    end

    assign irq_o = out_q.irq;

    if (PER_LINE_IRQ) begin : g_line_out
        assign irq_line_o = out_q.line;
    end else begin : g_no_line_out
        assign irq_line_o = '0;
    end

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|masked) |=> irq_o);

    // R9
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|masked) |=> !irq_o);

    // R8
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_q.line & $past(cfg_q.mask)) == '0));
endmodule

// File: tb/gpio_irq_unit_bench.sv
`timescale 1ns/1ps
module gpio_irq_unit_bench;
    localparam int DB = 4;
    localparam int L  = 5;
    localparam logic [7:0] A_EN  = 8'h30, A_MSK = 8'h34, A_TRG = 8'h38,
                           A_POL = 8'h3C, A_STA = 8'h40, A_RAW = 8'h44,
                           A_DEB = 8'h48, A_CLR = 8'h4C, A_PIN = 8'h50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [31:0] pins = '0;
    logic        irq_o;
    logic [31:0] irq_line_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    gpio_irq_unit #(.NLINES(32), .DB_LEN(DB), .ADDR_W(8), .PER_LINE_IRQ(1'b1)) u_gpio_irq_unit (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pins_i(pins),
        .irq_o(irq_o), .irq_line_o(irq_line_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk); penable = 1'b1;
        @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1'b1; pwrite = 1'b0; paddr = a;
        #1 d = prdata;
        psel = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: act=running exp=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] bitl;
        bitl = 32'h1 << L;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        chk("R1 irq_o", {31'b0, irq_o}, 32'h0);
        chk("R1 irq_line_o", irq_line_o, 32'h0);
        rd(A_EN, v);  chk("R1 enable", v, 0);
        rd(A_MSK, v); chk("R1 mask", v, 0);
        rd(A_TRG, v); chk("R1 trigger", v, 0);
        rd(A_POL, v); chk("R1 polarity", v, 0);
        rd(A_DEB, v); chk("R1 debounce", v, 0);
        rd(A_STA, v); chk("R1 status", v, 0);
        rd(A_RAW, v); chk("R1 raw", v, 0);

        // R2 readback
        wr(A_EN, 32'h1234_5678);  rd(A_EN, v);  chk("R2 enable", v, 32'h1234_5678);
        wr(A_MSK, 32'hDEAD_BEEF); rd(A_MSK, v); chk("R2 mask", v, 32'hDEAD_BEEF);
        wr(A_TRG, 32'h0F0F_00FF); rd(A_TRG, v); chk("R2 trigger", v, 32'h0F0F_00FF);
        wr(A_POL, 32'hC001_D00D); rd(A_POL, v); chk("R2 polarity", v, 32'hC001_D00D);
        wr(A_DEB, 32'h8000_0001); rd(A_DEB, v); chk("R2 debounce", v, 32'h8000_0001);
        wr(A_CLR, 32'hFFFF_FFFF); rd(A_CLR, v); chk("R2 clear reads zero", v, 0);
        wr(A_EN, 0); wr(A_MSK, 0); wr(A_TRG, 0); wr(A_POL, 0); wr(A_DEB, 0);
        wr(A_CLR, 32'hFFFF_FFFF);

        // R3 synchronized pin view
        @(negedge clk); pins = 32'hA5C3_0F96;
        rd(A_PIN, v); chk("R3 one edge old", v, 0);
        rd(A_PIN, v); chk("R3 two edges new", v, 32'hA5C3_0F96);
        @(negedge clk); pins = 0; cyc(4);

        // R4 R5 R6 R7 R8 R9 sweep of enable, mask, trigger, polarity on line L
        for (int c = 0; c < 16; c++) begin
            logic e, m, t, p;
            logic [31:0] exp_raw, exp_msk;
            string tag;
            e = c[0]; m = c[1]; t = c[2]; p = c[3];
            tag = !e ? "R4" : (t ? "R6" : "R5");
            @(negedge clk); pins = 0; pins[L] = ~p; cyc(5);
            wr(A_EN,  e ? bitl : 0);
            wr(A_MSK, m ? bitl : 0);
            wr(A_TRG, t ? bitl : 0);
            wr(A_POL, p ? bitl : 0);
            wr(A_CLR, 32'hFFFF_FFFF);
            cyc(2);
            rd(A_RAW, v); chk({tag, " idle"}, v, 0);
            @(negedge clk); pins[L] = p; cyc(6);
            exp_raw = e ? bitl : 0;
            exp_msk = m ? 0 : exp_raw;
            rd(A_RAW, v); chk({tag, " active raw"}, v, exp_raw);
            rd(A_STA, v); chk("R8 masked status", v, exp_msk);
            chk("R9 irq_o", {31'b0, irq_o}, {31'b0, |exp_msk});
            chk("R9 irq_line_o", irq_line_o, exp_msk);
            @(negedge clk); pins[L] = ~p; cyc(6);
            rd(A_RAW, v); chk({tag, " after return"}, v, (e && t) ? bitl : 0);
            wr(A_CLR, bitl); cyc(1);
            rd(A_RAW, v); chk("R7 cleared", v, 0);
        end

        // R7 per-bit clear leaves other bits
        @(negedge clk); pins = 0;
        wr(A_EN, 32'h6); wr(A_MSK, 0); wr(A_TRG, 32'h6); wr(A_POL, 32'h6); wr(A_DEB, 0);
        wr(A_CLR, 32'hFFFF_FFFF); cyc(2);
        @(negedge clk); pins = 32'h6; cyc(6);
        rd(A_RAW, v); chk("R6 two latched", v, 32'h6);
        wr(A_CLR, 32'h2); cyc(1);
        rd(A_RAW, v); chk("R7 only bit 1 cleared", v, 32'h4);
        chk("R9 irq stays", {31'b0, irq_o}, 32'h1);
        wr(A_CLR, 32'hFFFF_FFFF); cyc(2);
        chk("R9 irq drops", {31'b0, irq_o}, 32'h0);

        // R10 level latency, bit 0 active-high
        @(negedge clk); pins = 0;
        wr(A_EN, 32'h1); wr(A_TRG, 0); wr(A_POL, 32'h1); cyc(3);
        @(negedge clk); pins = 32'h1;
        cyc(2); chk("R10 level early", {31'b0, irq_o}, 0);
        cyc(1); chk("R10 level due", {31'b0, irq_o}, 1);
        @(negedge clk); pins = 0; cyc(5);

        // R10 edge latency, bit 0 rising
        wr(A_TRG, 32'h1); wr(A_CLR, 32'hFFFF_FFFF); cyc(2);
        @(negedge clk); pins = 32'h1;
        cyc(3); chk("R10 edge early", {31'b0, irq_o}, 0);
        cyc(1); chk("R10 edge due", {31'b0, irq_o}, 1);

        // R7 new edge wins over same-cycle clear
        @(negedge clk); pins = 0; cyc(5);
        rd(A_RAW, v); chk("R6 held before race", v, 32'h1);
        @(negedge clk); pins = 32'h1;
        @(posedge clk);
        @(negedge clk); psel = 1'b1; pwrite = 1'b1; paddr = A_CLR; pwdata = 32'h1;
        @(posedge clk);
        @(negedge clk); penable = 1'b1;
        @(posedge clk);
        @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        rd(A_RAW, v); chk("R7 set wins", v, 32'h1);
        wr(A_CLR, 32'h1); cyc(1);
        rd(A_RAW, v); chk("R7 plain clear", v, 0);

        // R11 debounce latency, bit 0 level-high
        @(negedge clk); pins = 0;
        wr(A_TRG, 0); wr(A_DEB, 32'h1); cyc(DB + 4);
        chk("R11 idle", {31'b0, irq_o}, 0);
        @(negedge clk); pins = 32'h1;
        cyc(2 + DB); chk("R11 debounce early", {31'b0, irq_o}, 0);
        cyc(1);      chk("R11 debounce due", {31'b0, irq_o}, 1);
        @(negedge clk); pins = 0; cyc(DB + 4);
        chk("R11 released", {31'b0, irq_o}, 0);

        // R11 short pulse ignored
        @(negedge clk); pins = 32'h1;
        repeat (DB - 1) @(negedge clk);
        pins = 0;
        for (int k = 0; k < DB + 6; k++) begin
            @(negedge clk);
            chk("R11 glitch ignored", {31'b0, irq_o}, 0);
        end
        rd(A_RAW, v); chk("R11 glitch raw", v, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule